// File: doc/BRIEF.md
# Bit-Reversed Result Reorder Buffer

This block sits after the final stage of a radix-2 transform engine. The final stage is computed out of place: it does not write its results back into the working bank. It writes them into this buffer, and they arrive in bit-reversed index order. The buffer keeps its own count of arrivals within the frame. It stores the k-th arrival at the address formed by reversing the log2(N) bits of k, so the frame sits in the storage in natural index order.

Once all N results of a frame have been stored, the frame is marked complete. A streaming valid/ready port then delivers the results at indices 0 through N-1, one per accepted transfer, and flags the final one. The completed frame stays readable until the engine writes the first final-stage result of the next frame. That write withdraws the frame and restarts the read side. The transform length is a power-of-two parameter, checked when the design is elaborated.

Top module: `fft_bitrev_outbuf`

## Requirements
- R1: After reset, `frame_valid` and `out_valid` are 0.
- R2: The k-th write of a frame (k counted from 0, `wr_en` high) is stored at index bitrev(k), where bitrev mirrors the log2(N) index bits (bit i moves to bit log2(N)-1-i). A read at index j returns the real and imaginary parts written at arrival k = bitrev(j).
- R3: `frame_valid` rises in the cycle after the N-th write of a frame and does not rise earlier.
- R4: The first write of a frame clears `frame_valid` and `out_valid` from the next cycle on. Any read in progress is abandoned, and the next read pass starts again at index 0.
- R5: While `frame_valid` is high, the read port presents indices 0, 1, ..., N-1 in that order on `out_idx`, advancing by one on each cycle with `out_valid` and `out_ready` both high. `out_last` is 1 exactly when index N-1 is presented.
- R6: While `out_valid` is high and `out_ready` is low, `out_idx`, `out_re` and `out_im` hold their values.
- R7: `out_valid` is never high without `frame_valid`. After the transfer that carries `out_last`, `out_valid` stays 0 while `frame_valid` stays 1, until another frame completes.
- R8: Cycles with `wr_en` low do not advance the arrival count, so gaps inside a frame leave the placement of R2 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Final-stage result present this cycle |
| wr_re | input | SAMPLE_W | Real part of the arriving result |
| wr_im | input | SAMPLE_W | Imaginary part of the arriving result |
| frame_valid | output | 1 | A complete frame is held |
| out_valid | output | 1 | Read port offers a result |
| out_ready | input | 1 | Reader accepts the offered result |
| out_idx | output | log2(N_PTS) | Natural index of the offered result |
| out_re | output | SAMPLE_W | Real part of the offered result |
| out_im | output | SAMPLE_W | Imaginary part of the offered result |
| out_last | output | 1 | Offered result is index N-1 |

## Verification
The hardest case to reach is a new frame's first write landing while a read pass is part-way through the stored frame under back-pressure. The read pointer must then be dropped and restarted, not resumed. The stimulus gets there with a reader that refuses every third cycle. It starts the next frame a few transfers into the read pass and then stalls the reader outright. An earlier frame written with idle gaps between arrivals shows that only real writes move the arrival count.

// File: rtl/outbuf_pkg.sv
package outbuf_pkg;

   // true when v is a power of two and at least two
   function automatic bit len_ok(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

   // natural index presented on the read side after reset or a drain
   localparam int unsigned RD_FIRST = 0;

endpackage

// File: rtl/outbuf_wr_ctrl.sv
module outbuf_wr_ctrl #(
   parameter int N_PTS = 16,
   localparam int AW = $clog2(N_PTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic          frame_start,
   output logic          frame_done,
   output logic          frame_valid
);

   localparam logic [AW-1:0] LAST_ARRIVAL = AW'(N_PTS - 1);

   logic [AW-1:0] arrival_q;

   // mirrored wiring of the arrival count onto the store address
   for (genvar b = 0; b < AW; b++) begin : g_mirror
      assign wr_addr[b] = arrival_q[AW-1-b];
   end

   assign frame_start = wr_en && (arrival_q == '0);
   assign frame_done  = wr_en && (arrival_q == LAST_ARRIVAL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arrival_q   <= '0;
         frame_valid <= 1'b0;
      end else if (wr_en) begin
         arrival_q <= arrival_q + 1'b1;
         if (frame_done) begin
            frame_valid <= 1'b1;
         end else if (frame_start) begin
            frame_valid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/outbuf_store.sv
module outbuf_store #(
   parameter int N_PTS          = 16,
   parameter int WORD_W         = 32,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW = $clog2(N_PTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [WORD_W-1:0] rdata
);

   logic [WORD_W-1:0] cells [N_PTS];

   if (CLEAR_ON_RESET) begin : g_clr
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < N_PTS; i++) begin
               cells[i] <= '0;
            end
         end else if (we) begin
            cells[waddr] <= wdata;
         end
      end
   end else begin : g_noclr
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) begin
         if (we) begin
            cells[waddr] <= wdata;
         end
      end
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/outbuf_rd_ctrl.sv
module outbuf_rd_ctrl #(
   parameter int N_PTS = 16,
   localparam int AW = $clog2(N_PTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_start,
   input  logic          frame_done,
   input  logic          frame_valid,
   input  logic          out_ready,
   output logic [AW-1:0] rd_addr,
   output logic          out_valid,
   output logic          out_last
);

   localparam logic [AW-1:0] LAST_IDX  = AW'(N_PTS - 1);
   localparam logic [AW-1:0] FIRST_IDX = AW'(outbuf_pkg::RD_FIRST);

   logic [AW-1:0] ptr_q;
   logic          spent_q;
   logic          take;

   assign rd_addr   = ptr_q;
   assign out_valid = frame_valid && !spent_q;
   assign out_last  = (ptr_q == LAST_IDX);
   assign take      = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q   <= FIRST_IDX;
         spent_q <= 1'b1;
      end else if (frame_start) begin
         ptr_q   <= FIRST_IDX;
         spent_q <= 1'b1;
      end else if (frame_done) begin
         ptr_q   <= FIRST_IDX;
         spent_q <= 1'b0;
      end else if (take) begin
         if (out_last) begin
            ptr_q   <= FIRST_IDX;
            spent_q <= 1'b1;
         end else begin
            ptr_q <= ptr_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/fft_bitrev_outbuf.sv
module fft_bitrev_outbuf #(
   parameter int N_PTS          = 16,
   parameter int SAMPLE_W       = 16,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW     = $clog2(N_PTS),
   localparam int WORD_W = 2 * SAMPLE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SAMPLE_W-1:0] wr_re,
   input  logic [SAMPLE_W-1:0] wr_im,
   output logic                frame_valid,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [AW-1:0]       out_idx,
   output logic [SAMPLE_W-1:0] out_re,
   output logic [SAMPLE_W-1:0] out_im,
   output logic                out_last
);

   if (!outbuf_pkg::len_ok(N_PTS)) begin : g_bad_len
      $error("N_PTS must be a power of two of at least 2");
   end
   if (SAMPLE_W < 1) begin : g_bad_w
      $error("SAMPLE_W must be positive");
   end

   logic [AW-1:0]     wr_addr;
   logic [AW-1:0]     rd_addr;
   logic              frame_start;
   logic              frame_done;
   logic [WORD_W-1:0] rd_word;

   outbuf_wr_ctrl #(.N_PTS(N_PTS)) u_wr (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .frame_start (frame_start),
      .frame_done  (frame_done),
      .frame_valid (frame_valid)
   );

   outbuf_store #(
      .N_PTS          (N_PTS),
      .WORD_W         (WORD_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata ({wr_re, wr_im}),
      .raddr (rd_addr),
      .rdata (rd_word)
   );

   outbuf_rd_ctrl #(.N_PTS(N_PTS)) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .frame_done  (frame_done),
      .frame_valid (frame_valid),
      .out_ready   (out_ready),
      .rd_addr     (rd_addr),
      .out_valid   (out_valid),
      .out_last    (out_last)
   );

   assign out_idx = rd_addr;
   assign out_re  = rd_word[WORD_W-1:SAMPLE_W];
   assign out_im  = rd_word[SAMPLE_W-1:0];

endmodule

// File: rtl/outbuf_chk.sv
module outbuf_chk #(
   parameter int N_PTS    = 16,
   parameter int SAMPLE_W = 16,
   localparam int AW = $clog2(N_PTS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic                frame_valid,
   input logic                out_valid,
   input logic                out_ready,
   input logic [AW-1:0]       out_idx,
   input logic [SAMPLE_W-1:0] out_re,
   input logic [SAMPLE_W-1:0] out_im,
   input logic                out_last
);

   localparam logic [AW-1:0] TOP = AW'(N_PTS - 1);

   // independent count of arrivals seen at the ports
   logic [AW-1:0] seen_q;
   always_ff @(posedge clk) begin
      if (!rst_n)     seen_q <= '0;
      else if (wr_en) seen_q <= seen_q + 1'b1;
   end

   // R3
   frame_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && seen_q == TOP |=> frame_valid);

   // R3
   no_early_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid && !(wr_en && seen_q == TOP) |=> !frame_valid);

   // R4
   frame_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && seen_q == '0 |=> !frame_valid && !out_valid);

   // R7
   valid_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> frame_valid);

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && !wr_en |=>
         out_valid && $stable(out_idx) && $stable(out_re) && $stable(out_im));

   // R5
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && !out_last && !wr_en |=>
         out_valid && out_idx == AW'($past(out_idx) + 1'b1));

   // R7
   drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last && !wr_en |=> !out_valid && frame_valid);

endmodule

bind fft_bitrev_outbuf outbuf_chk #(.N_PTS(N_PTS), .SAMPLE_W(SAMPLE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .frame_valid (frame_valid),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_idx     (out_idx),
   .out_re      (out_re),
   .out_im      (out_im),
   .out_last    (out_last)
);

// File: tb/fft_bitrev_outbuf_tb.sv
`timescale 1ns/1ps
module fft_bitrev_outbuf_tb;

   localparam int N  = 16;
   localparam int SW = 16;
   localparam int AW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [SW-1:0] wr_re = '0;
   logic [SW-1:0] wr_im = '0;
   logic          frame_valid, out_valid, out_last;
   logic          out_ready = 1'b0;
   logic [AW-1:0] out_idx;
   logic [SW-1:0] out_re, out_im;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int rdy_mode = 0;

   always #2 clk = ~clk;

   fft_bitrev_outbuf #(.N_PTS(N), .SAMPLE_W(SW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_re(wr_re), .wr_im(wr_im),
      .frame_valid(frame_valid), .out_valid(out_valid), .out_ready(out_ready),
      .out_idx(out_idx), .out_re(out_re), .out_im(out_im), .out_last(out_last)
   );

   function automatic int mirror(input int k);
      int r = 0;
      for (int b = 0; b < AW; b++) if (k[b]) r |= 1 << (AW - 1 - b);
      return r;
   endfunction

   // behavioural reference: natural-order image and read progress
   int      m_arr = 0;
   bit      m_fv  = 0;
   bit      m_spent = 1;
   int      m_pos = 0;
   int      nat_re [N];
   int      nat_im [N];
   bit      m_stall = 0;
   logic [AW-1:0] p_idx;
   logic [SW-1:0] p_re, p_im;

   always @(posedge clk) begin
      cyc++;
      m_stall = rst_n && out_valid && !out_ready && !wr_en;
      p_idx = out_idx; p_re = out_re; p_im = out_im;
      if (!rst_n) begin
         m_arr = 0; m_fv = 0; m_spent = 1; m_pos = 0;
      end else if (wr_en) begin
         nat_re[mirror(m_arr)] = int'(wr_re);
         nat_im[mirror(m_arr)] = int'(wr_im);
         if (m_arr == 0)          begin m_fv = 0; m_spent = 1; m_pos = 0; end
         else if (m_arr == N - 1) begin m_fv = 1; m_spent = 0; m_pos = 0; end
         m_arr = (m_arr + 1) % N;
      end else if (m_fv && !m_spent && out_ready) begin
         if (m_pos == N - 1) begin m_spent = 1; m_pos = 0; end
         else m_pos++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && cyc > 0) begin
         chk(frame_valid == m_fv, "R3 R4", "frame_valid", frame_valid, m_fv);
         chk(out_valid == (m_fv && !m_spent), "R7", "out_valid", out_valid, m_fv && !m_spent);
         if (m_fv && !m_spent) begin
            chk(int'(out_idx) == m_pos, "R5", "out_idx", out_idx, m_pos);
            chk(out_last == (m_pos == N - 1), "R5", "out_last", out_last, m_pos == N - 1);
            chk(int'(out_re) == nat_re[m_pos], "R2 R8", "out_re", out_re, nat_re[m_pos]);
            chk(int'(out_im) == nat_im[m_pos], "R2 R8", "out_im", out_im, nat_im[m_pos]);
         end
         if (m_stall) begin
            chk(out_idx == p_idx && out_re == p_re && out_im == p_im, "R6",
                "held idx", out_idx, p_idx);
         end
      end
   end

   // reader behaviour: 0 always ready, 1 refuses every third cycle, 2 stalled
   always @(negedge clk) begin
      case (rdy_mode)
         0:       out_ready = 1'b1;
         1:       out_ready = (cyc % 3) != 0;
         default: out_ready = 1'b0;
      endcase
   end

   task automatic write_frame(input int f, input int gap);
      for (int k = 0; k < N; k++) begin
         @(negedge clk);
         wr_en = 1'b1;
         wr_re = SW'(f * 256 + mirror(k) * 5 + 1);
         wr_im = SW'(~(f * 97 + k));
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            wr_en = 1'b0;
         end
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      fork
         begin
            repeat (4) @(negedge clk);
            rst_n = 1'b1;
            // R1: reset state
            chk(frame_valid == 1'b0, "R1", "frame_valid after reset", frame_valid, 0);
            chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
            // R2 R3 R5: contiguous frame, free-running reader
            rdy_mode = 0;
            write_frame(1, 0);
            repeat (24) @(negedge clk);
            // R7: drained frame stays held
            chk(frame_valid && !out_valid, "R7", "held after drain", out_valid, 0);
            // R8: gaps between arrivals, reader with back-pressure
            rdy_mode = 1;
            write_frame(2, 2);
            repeat (7) @(negedge clk);
            // R4: next frame starts mid-read, then a full stall (R6)
            write_frame(3, 0);
            rdy_mode = 2;
            repeat (6) @(negedge clk);
            rdy_mode = 1;
            repeat (40) @(negedge clk);
            chk(frame_valid && !out_valid, "R7", "held after drain", out_valid, 0);
         end
         begin
            repeat (5000) @(posedge clk);
            bad++; total++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule